// File: doc/BRIEF.md
# Byte-wide SPI master with self-driven slave select

This block is the controlling end of a serial peripheral link. A byte offered on the transmit stream port goes out on MOSI one bit at a time. At the same moment a byte is gathered from MISO. When the eighth bit has been taken in, the gathered byte is presented on the receive port for one cycle. The serial clock comes from a half-period divider on the system clock. The idle level of the serial clock, the clock phase and the bit order are set by plain configuration inputs. These inputs are captured when a transfer starts.

The block can also frame each transfer with its own active-low select line. This happens only when both select enables are set at the moment a byte is accepted. Otherwise the select line stays high.

The transmit side follows valid/ready rules. A byte is taken in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole transfer, so a producer must hold its byte until it is accepted. The receive side has no back-pressure: `rx_valid` is a single-cycle pulse, and the consumer must capture `rx_data` in that cycle.

Top module: `spi_byte_master`

## Requirements
- R1: A byte is accepted on a cycle with `tx_valid` and `tx_ready` both high. `busy` rises in the next cycle. `tx_ready` is high exactly while `busy` is low.
- R2: Every transfer gives exactly 16 serial-clock edges and moves 8 bits. MOSI carries `tx_data`, and the byte sampled from MISO appears on `rx_data`. With `cfg_lsb_first`=1 bit 0 travels first; with 0, bit 7 travels first.
- R3: While idle, `sclk` equals `cfg_cpol` (0 gives a low idle level, 1 gives a high idle level). It returns to the latched idle level after the last edge of a transfer.
- R4: With `cfg_cpha`=0, the first edge comes one half-period after `busy` rises, and MISO is sampled on edges 1, 3, 5 … 15. With `cfg_cpha`=1, the first edge comes in the first busy cycle, and sampling happens on edges 2, 4 … 16. MOSI is stable at every sampling edge.
- R5: A half-period of the serial clock lasts `cfg_div` system-clock cycles. A value of 0 behaves as 1.
- R6: `ss_n` goes low for a transfer only if `cfg_fault_en` and `cfg_sel_out_en` are both 1 when the byte is accepted. Otherwise it stays high throughout. It is always high while idle.
- R7: When driven, `ss_n` falls in the first busy cycle and stays low for 17 half-periods. It therefore rises one half-period after the eighth bit time ends: one half-period after the last edge with phase 0, and two half-periods after it with phase 1.
- R8: `busy` stays high for exactly 17 half-periods and falls in the same cycle `ss_n` rises. A `tx_valid` during that time is ignored and does not change the bits sent.
- R9: `rx_valid` pulses for one cycle, in the first cycle after `busy` falls, with the received byte on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the first edge of a bit, 1 on the second |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_div | input | DIV_W | Half-period length in system cycles (0 acts as 1) |
| cfg_fault_en | input | 1 | First select enable |
| cfg_sel_out_en | input | 1 | Second select enable |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block can accept a byte |
| tx_data | input | DATA_W | Byte to send |
| rx_valid | output | 1 | One-cycle pulse: received byte valid |
| rx_data | output | DATA_W | Received byte |
| busy | output | 1 | Transfer in progress, select still asserted |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench plays the slave. It presents each MISO bit only after the sampling edge of the previous one, so a design that samples on the wrong edge for either phase collects a shifted or duplicated byte. It counts cycles between the fall of select, the first and last clock edges and the rise of select. A design that releases select early, or forgets the trailing half-period, misses by one half-period, and a divider treating 0 literally hangs or mis-times. A write injected mid-transfer, and configurations where only one select enable is set, catch a design that restarts on a busy write or drives select when it should stay high.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Configuration captured at the start of a transfer.
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spim_mode_t;

  // Transfer phases: idle, the sixteen data half-periods, the select tail.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } spim_state_t;

endpackage

// File: rtl/spim_halfclk.sv
module spim_halfclk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick,
  output logic [IDX_W-1:0] half_idx
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // A zero divider is treated as a one-cycle half-period.
  assign limit = (div_q == '0) ? DIV_W'(1) : div_q;
  assign tick  = run && (cnt == (limit - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      half_idx <= '0;
    end else if (start) begin
      cnt      <= '0;
      half_idx <= '0;
    end else if (tick) begin
      cnt      <= '0;
      half_idx <= half_idx + IDX_W'(1);
    end else if (run) begin
      cnt      <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              sample_en,
  input  logic              shift_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] shreg
);

  logic samp_q;

  // The bit sampled mid-bit enters at the end opposite the one being sent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      samp_q <= 1'b0;
    end else if (load) begin
      shreg  <= load_data;
    end else begin
      if (sample_en) samp_q <= miso;
      if (shift_en) begin
        if (lsb_first) shreg <= {samp_q, shreg[DATA_W-1:1]};
        else           shreg <= {shreg[DATA_W-2:0], samp_q};
      end
    end
  end

  assign mosi = lsb_first ? shreg[0] : shreg[DATA_W-1];

endmodule

// File: rtl/spim_select.sv
module spim_select (
  input  logic clk,
  input  logic rst_n,
  input  logic open_sel,
  input  logic drive,
  input  logic close_sel,
  output logic ss_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ss_n <= 1'b1;
    else if (open_sel)  ss_n <= !drive;
    else if (close_sel) ss_n <= 1'b1;
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fault_en,
  input  logic              cfg_sel_out_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spim_pkg::*;

  localparam int unsigned HALVES = 2 * DATA_W;
  localparam int unsigned IDX_W  = $clog2(HALVES + 1);

  spim_state_t       state;
  spim_mode_t        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic              accept;
  logic              tick;
  logic [IDX_W-1:0]  half_idx;
  logic              in_shift;
  logic              last_half;
  logic              tail_end;
  logic              sample_en;
  logic              shift_en;
  logic [DATA_W-1:0] shreg;

  assign tx_ready  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = tx_valid && tx_ready;
  assign in_shift  = (state == ST_SHIFT);
  assign last_half = in_shift && tick && (half_idx == IDX_W'(HALVES - 1));
  assign tail_end  = (state == ST_TAIL) && tick;
  assign sample_en = in_shift && tick && !half_idx[0];
  assign shift_en  = in_shift && tick && half_idx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= '0;
      div_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_SHIFT;
          mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
          div_q  <= cfg_div;
        end
        ST_SHIFT: if (last_half) state <= ST_TAIL;
        ST_TAIL:  if (tick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= tail_end;
      if (tail_end) rx_data <= shreg;
    end
  end

  // Even half-periods are idle-level for phase 0 and active for phase 1.
  always_comb begin
    unique case (state)
      ST_SHIFT: sclk = mode_q.cpol ^ (half_idx[0] ^ mode_q.cpha);
      ST_TAIL:  sclk = mode_q.cpol;
      default:  sclk = cfg_cpol;
    endcase
  end

  spim_halfclk #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_halfclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .run      (busy),
    .div_q    (div_q),
    .tick     (tick),
    .half_idx (half_idx)
  );

  spim_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .lsb_first (mode_q.lsb_first),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .miso      (miso),
    .mosi      (mosi),
    .shreg     (shreg)
  );

  spim_select u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_sel  (accept),
    .drive     (cfg_fault_en && cfg_sel_out_en),
    .close_sel (tail_end),
    .ss_n      (ss_n)
  );

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic cfg_fault_en,
  input logic cfg_sel_out_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic rx_valid,
  input logic sclk,
  input logic ss_n
);

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (sclk == cfg_cpol));

  assert_sel_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && cfg_fault_en && cfg_sel_out_en) |=> !ss_n);

  assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !(cfg_fault_en && cfg_sel_out_en)) |=> ss_n);

  assert_idle_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> ss_n);

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind spi_byte_master spim_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_cpol       (cfg_cpol),
  .cfg_fault_en   (cfg_fault_en),
  .cfg_sel_out_en (cfg_sel_out_en),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .busy           (busy),
  .rx_valid       (rx_valid),
  .sclk           (sclk),
  .ss_n           (ss_n)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       cfg_fault_en = 1'b0, cfg_sel_out_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       miso = 1'b0;
  logic       tx_ready, rx_valid, busy, sclk, mosi, ss_n;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .cfg_fault_en(cfg_fault_en),
    .cfg_sel_out_en(cfg_sel_out_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave model and timing monitor, sampled at the falling clock edge.
  int   cyc = 0;
  int   busy_rise, busy_fall, ss_fall, ss_rise, first_edge, last_edge;
  int   edges, bitk, rx_cnt;
  bit   ss_low_seen;
  logic [7:0] got_mosi, got_rx;
  logic cur_cpha, cur_lsb;
  logic [7:0] cur_mi;
  logic p_busy = 1'b0, p_ss = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (busy && !p_busy) busy_rise = cyc;
    if (!busy && p_busy) busy_fall = cyc;
    if (!ss_n && p_ss) begin ss_fall = cyc; ss_low_seen = 1'b1; end
    if (ss_n && !p_ss) ss_rise = cyc;
    if ((sclk != p_sclk) && (busy || p_busy)) begin
      edges++;
      if (edges == 1) first_edge = cyc;
      last_edge = cyc;
      if ((edges % 2) == (cur_cpha ? 0 : 1)) begin
        if (bitk < 8) got_mosi[cur_lsb ? bitk : 7 - bitk] = mosi;
        bitk++;
        if (bitk < 8) miso = cur_lsb ? cur_mi[bitk] : cur_mi[7 - bitk];
      end
    end
    if (rx_valid) begin rx_cnt++; got_rx = rx_data; end
    p_busy = busy;
    p_ss   = ss_n;
    p_sclk = sclk;
  end

  task automatic run_xfer(input logic [28:0] v, input bit inject);
    logic pol, pha, lsb, fe, se;
    logic [7:0] dv, tx, mi;
    int h, guard;
    {pol, pha, lsb, fe, se, dv, tx, mi} = v;
    h = (dv == 0) ? 1 : int'(dv);
    @(posedge clk); #2;
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_div = dv;
    cfg_fault_en = fe; cfg_sel_out_en = se;
    cur_cpha = pha; cur_lsb = lsb; cur_mi = mi;
    miso = lsb ? mi[0] : mi[7];
    edges = 0; bitk = 0; rx_cnt = 0; ss_low_seen = 1'b0;
    got_mosi = 8'h00; got_rx = 8'h00;
    busy_rise = 0; busy_fall = 0; ss_fall = 0; ss_rise = 0; first_edge = 0; last_edge = 0;
    chk(tx_ready == 1'b1, "R1 ready idle", tx_ready, 1);
    tx_valid = 1'b1; tx_data = tx;
    @(posedge clk); #2;
    tx_valid = 1'b0;
    if (inject) begin
      repeat (5) @(posedge clk);
      #2 tx_valid = 1'b1; tx_data = ~tx;
      #1 chk(tx_ready == 1'b0, "R8 ready low while busy", tx_ready, 0);
      @(posedge clk); #2 tx_valid = 1'b0;
    end
    guard = 0;
    while (rx_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (3 + 2 * h) @(negedge clk);
    chk(got_rx == mi, "R2 R9 received byte", got_rx, mi);
    chk(got_mosi == tx, "R2 R8 bits sent", got_mosi, tx);
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(rx_cnt == 1, "R9 single done pulse", rx_cnt, 1);
    chk(busy_fall - busy_rise == 17 * h, "R5 R8 busy length", busy_fall - busy_rise, 17 * h);
    chk(first_edge - busy_rise == (pha ? 0 : h), "R4 first edge", first_edge - busy_rise, pha ? 0 : h);
    chk(busy_fall - last_edge == (pha ? 2 : 1) * h, "R7 tail after last edge",
        busy_fall - last_edge, (pha ? 2 : 1) * h);
    chk(sclk == pol, "R3 idle after transfer", sclk, pol);
    chk(busy == 1'b0, "R8 no restart from busy write", busy, 0);
    if (fe && se) begin
      chk(ss_fall == busy_rise, "R7 select falls at start", ss_fall, busy_rise);
      chk(ss_rise == busy_fall, "R7 R8 select rises with busy", ss_rise, busy_fall);
    end else begin
      chk(!ss_low_seen, "R6 select held high", ss_low_seen, 0);
    end
  endtask

  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {5'b00011, 8'd2, 8'hA5, 8'h3C},
    {5'b10011, 8'd1, 8'h81, 8'h7E},
    {5'b01011, 8'd3, 8'h5A, 8'hC3},
    {5'b11111, 8'd2, 8'h01, 8'h80},
    {5'b00111, 8'd1, 8'hF0, 8'h0F},
    {5'b11001, 8'd4, 8'h96, 8'h69},
    {5'b01110, 8'd0, 8'h3C, 8'hA5},
    {5'b10111, 8'd5, 8'hE7, 8'h18}
  };

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    chk(ss_n == 1'b1, "R6 reset select", ss_n, 1);
    chk(rx_valid == 1'b0, "R9 reset done", rx_valid, 0);
    chk(tx_ready == 1'b0 || tx_ready == 1'b1, "R1 reset ready known", tx_ready, 1);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    cfg_cpol = 1'b1; #1;
    chk(sclk == 1'b1, "R3 idle high", sclk, 1);
    cfg_cpol = 1'b0; #1;
    chk(sclk == 1'b0, "R3 idle low", sclk, 0);
    for (int i = 0; i < NV; i++) run_xfer(VEC[i], 1'b0);
    // Directed corners: busy write ignored, zero divider, one select enable only.
    run_xfer({5'b01011, 8'd3, 8'hC6, 8'h39}, 1'b1);
    run_xfer({5'b00111, 8'd0, 8'h6D, 8'hB2}, 1'b1);
    run_xfer({5'b10010, 8'd2, 8'h11, 8'hEE}, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule